// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block turns the contents of four 5-bit cartridge control registers into the physical bank numbers that a cartridge board presents to its memories. It produces a 16 KB bank number for each of the two program ROM windows, a 4 KB bank number for each of the two pattern (CHR) windows, a nametable mirroring code, and a work RAM enable. For boards with more than one RAM bank it also produces a RAM bank number and a battery-or-work RAM select.

The serial loader that fills the registers sits elsewhere. It feeds this block the current register values and a flag that says whether the second CHR register was written more recently than the first. Board properties are elaboration parameters: the program ROM size, the RAM size, whether the 16 KB RAM is split into battery and work halves, whether a battery is fitted, whether RAM is forced on, and whether the program ROM is fixed. Every output is registered. A register change shows at the outputs one clock later and needs no further writes.

Top module: `cart_bank_xlate`

## Requirements
- R1: `mirror` follows control bits 1:0, and the code values keep their meaning: 0 is single-screen lower, 1 is single-screen upper, 2 is vertical, 3 is horizontal.
- R2: With control bit 3 clear and a banked ROM, the windows map the consecutive banks `{hb, prg[3:1], 0}` and `{hb, prg[3:1], 1}`.
- R3: With control bit 3 set and control bit 2 set, the low window maps `{hb, prg[3:0]}` and the high window maps `{hb, 4'hF}`. With bit 3 set and bit 2 clear, the low window maps `{hb, 4'h0}` and the high window maps `{hb, prg[3:0]}`.
- R4: With control bit 4 set, the CHR windows are `chr0` and `chr1`, all 5 bits of each. With bit 4 clear, they are `{chr0[4:1],0}` and `{chr0[4:1],1}`.
- R5: The active CHR register is `chr1` only when `chr1_last` is 1 and control bit 4 is set. In every other case it is `chr0`.
- R6: `hb` is bit 4 of the active CHR register when PRG_ROM_KB is 512. For any other ROM size it is 0.
- R7: `ram_en` is 0 when prg bit 4 is set, unless FORCE_RAM_ON is 1. In all other cases it is 1.
- R8: With more than 16 KB of RAM, `ram_bank` is bits 3:2 of the active CHR register, and `ram_battery` equals HAS_BATTERY.
- R9: With a split 16 KB RAM, `ram_bank` is 0. `ram_battery` is 1 when bit 3 of the active CHR register is clear and 0 when it is set. With 8 KB or less of RAM, `ram_bank` is 0 and `ram_battery` equals HAS_BATTERY.
- R10: With FIXED_PRG set, the windows map banks 0 and 1 whatever the register values.
- R11: While `rst_n` is low, every output is 0. After reset, each output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_reg | input | 5 | Mode register: mirroring, PRG slot, PRG size, CHR size |
| chr0_reg | input | 5 | First CHR bank register |
| chr1_reg | input | 5 | Second CHR bank register |
| prg_reg | input | 5 | PRG bank register; bit 4 disables RAM |
| chr1_last | input | 1 | The second CHR register was written last |
| prg_bank_lo | output | 5 | 16 KB bank for the low program window |
| prg_bank_hi | output | 5 | 16 KB bank for the high program window |
| chr_bank_lo | output | 5 | 4 KB bank for the low pattern window |
| chr_bank_hi | output | 5 | 4 KB bank for the high pattern window |
| mirror | output | 2 | Nametable mirroring code |
| ram_en | output | 1 | Work RAM mapped |
| ram_bank | output | 2 | Work RAM bank |
| ram_battery | output | 1 | Selected RAM is battery backed |

## Verification
The bench elaborates three copies of the block. The first uses a 512 KB ROM with 32 KB of battery RAM, so that the high program bit and the two-bit RAM banking can both be observed. The second uses a fixed 256 KB ROM with a split 16 KB RAM and forced-on RAM, which exposes fixed-PRG mode, the battery/work select and the RAM-disable override. The third uses a 256 KB ROM with 8 KB of RAM and no battery, which shows that the high bit and the bank select stay at zero on a small board.

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate #(
  parameter int PRG_ROM_KB   = 512,
  parameter int RAM_KB       = 32,
  parameter bit SPLIT_RAM    = 1'b0,
  parameter bit HAS_BATTERY  = 1'b1,
  parameter bit FORCE_RAM_ON = 1'b0,
  parameter bit FIXED_PRG    = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] ctrl_reg,
  input  logic [4:0] chr0_reg,
  input  logic [4:0] chr1_reg,
  input  logic [4:0] prg_reg,
  input  logic       chr1_last,
  output logic [4:0] prg_bank_lo,
  output logic [4:0] prg_bank_hi,
  output logic [4:0] chr_bank_lo,
  output logic [4:0] chr_bank_hi,
  output logic [1:0] mirror,
  output logic       ram_en,
  output logic [1:0] ram_bank,
  output logic       ram_battery
);

  localparam bit HIGH_PRG_BIT = (PRG_ROM_KB == 512);
  localparam bit RAM_BANKED4  = (RAM_KB > 16);
  localparam bit RAM_BANKED2  = (RAM_KB > 8) && (RAM_KB <= 16) && !SPLIT_RAM;
  localparam bit RAM_SPLIT    = (RAM_KB > 8) && (RAM_KB <= 16) && SPLIT_RAM;

  logic       chr_4k, prg_16k, slot_lo;
  logic [2:0] act;
  logic       hb;
  logic [4:0] n_prg_lo, n_prg_hi, n_chr_lo, n_chr_hi;
  logic [1:0] n_bank;
  logic       n_batt, n_en;

  assign chr_4k  = ctrl_reg[4];
  assign prg_16k = ctrl_reg[3];
  assign slot_lo = ctrl_reg[2];

  assign act = (chr1_last && chr_4k) ? chr1_reg[4:2] : chr0_reg[4:2];
  assign hb  = HIGH_PRG_BIT ? act[2] : 1'b0;

  always_comb begin
    if (FIXED_PRG) begin
      n_prg_lo = 5'd0;
      n_prg_hi = 5'd1;
    end else if (!prg_16k) begin
      n_prg_lo = {hb, prg_reg[3:1], 1'b0};
      n_prg_hi = {hb, prg_reg[3:1], 1'b1};
    end else if (slot_lo) begin
      n_prg_lo = {hb, prg_reg[3:0]};
      n_prg_hi = {hb, 4'hF};
    end else begin
      n_prg_lo = {hb, 4'h0};
      n_prg_hi = {hb, prg_reg[3:0]};
    end
  end

  assign n_chr_lo = chr_4k ? chr0_reg : {chr0_reg[4:1], 1'b0};
  assign n_chr_hi = chr_4k ? chr1_reg : {chr0_reg[4:1], 1'b1};

  assign n_en = FORCE_RAM_ON || !prg_reg[4];

  always_comb begin
    n_bank = 2'd0;
    n_batt = HAS_BATTERY;
    if (RAM_BANKED4) begin
      n_bank = act[1:0];
    end else if (RAM_BANKED2) begin
      n_bank = {1'b0, act[0]};
    end else if (RAM_SPLIT) begin
      n_batt = !act[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_bank_lo <= '0;
      prg_bank_hi <= '0;
      chr_bank_lo <= '0;
      chr_bank_hi <= '0;
      mirror      <= '0;
      ram_en      <= 1'b0;
      ram_bank    <= '0;
      ram_battery <= 1'b0;
    end else begin
      prg_bank_lo <= n_prg_lo;
      prg_bank_hi <= n_prg_hi;
      chr_bank_lo <= n_chr_lo;
      chr_bank_hi <= n_chr_hi;
      mirror      <= ctrl_reg[1:0];
      ram_en      <= n_en;
      ram_bank    <= n_bank;
      ram_battery <= n_batt;
    end
  end

endmodule

// File: rtl/cart_bank_xlate_chk.sv
module cart_bank_xlate_chk #(
  parameter bit FIXED_PRG    = 1'b0,
  parameter bit FORCE_RAM_ON = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] ctrl_reg,
  input logic [4:0] prg_reg,
  input logic [4:0] prg_bank_lo,
  input logic [4:0] prg_bank_hi,
  input logic [4:0] chr_bank_lo,
  input logic [4:0] chr_bank_hi,
  input logic [1:0] mirror,
  input logic       ram_en
);

  a_r1_mirror_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> mirror == $past(ctrl_reg[1:0]));

  a_r2_pair_even_odd: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ctrl_reg[3])) |->
      (prg_bank_lo[0] == 1'b0 && prg_bank_hi == (prg_bank_lo | 5'd1)));

  a_r4_chr_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ctrl_reg[4])) |->
      (chr_bank_lo[0] == 1'b0 && chr_bank_hi == (chr_bank_lo | 5'd1)));

  a_r7_ram_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(prg_reg[4]) && !FORCE_RAM_ON) |-> !ram_en);

  a_r10_fixed_prg: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && FIXED_PRG) |-> (prg_bank_lo == 5'd0 && prg_bank_hi == 5'd1));

  a_r11_reset_zero: assert property (@(posedge clk)
    $past(!rst_n) |-> (prg_bank_lo == 5'd0 && chr_bank_hi == 5'd0 && !ram_en));

endmodule

bind cart_bank_xlate cart_bank_xlate_chk #(
  .FIXED_PRG(FIXED_PRG),
  .FORCE_RAM_ON(FORCE_RAM_ON)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .ctrl_reg(ctrl_reg),
  .prg_reg(prg_reg),
  .prg_bank_lo(prg_bank_lo),
  .prg_bank_hi(prg_bank_hi),
  .chr_bank_lo(chr_bank_lo),
  .chr_bank_hi(chr_bank_hi),
  .mirror(mirror),
  .ram_en(ram_en)
);

// File: tb/cart_bank_xlate_tb_top.sv
module cart_bank_xlate_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] ctrl = '0, c0 = '0, c1 = '0, prg = '0;
  logic last = 1'b0;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  logic [4:0] a_plo, a_phi, a_clo, a_chi;
  logic [1:0] a_mir, a_bank;
  logic a_en, a_batt;
  cart_bank_xlate dut_i (.clk(clk), .rst_n(rst_n), .ctrl_reg(ctrl), .chr0_reg(c0),
    .chr1_reg(c1), .prg_reg(prg), .chr1_last(last), .prg_bank_lo(a_plo),
    .prg_bank_hi(a_phi), .chr_bank_lo(a_clo), .chr_bank_hi(a_chi), .mirror(a_mir),
    .ram_en(a_en), .ram_bank(a_bank), .ram_battery(a_batt));

  logic [4:0] b_plo, b_phi, b_clo, b_chi;
  logic [1:0] b_mir, b_bank;
  logic b_en, b_batt;
  cart_bank_xlate #(.PRG_ROM_KB(256), .RAM_KB(16), .SPLIT_RAM(1'b1), .HAS_BATTERY(1'b1),
    .FORCE_RAM_ON(1'b1), .FIXED_PRG(1'b1)) dut_fx (.clk(clk), .rst_n(rst_n),
    .ctrl_reg(ctrl), .chr0_reg(c0), .chr1_reg(c1), .prg_reg(prg), .chr1_last(last),
    .prg_bank_lo(b_plo), .prg_bank_hi(b_phi), .chr_bank_lo(b_clo), .chr_bank_hi(b_chi),
    .mirror(b_mir), .ram_en(b_en), .ram_bank(b_bank), .ram_battery(b_batt));

  logic [4:0] s_plo, s_phi, s_clo, s_chi;
  logic [1:0] s_mir, s_bank;
  logic s_en, s_batt;
  cart_bank_xlate #(.PRG_ROM_KB(256), .RAM_KB(8), .HAS_BATTERY(1'b0)) dut_sm (
    .clk(clk), .rst_n(rst_n), .ctrl_reg(ctrl), .chr0_reg(c0), .chr1_reg(c1),
    .prg_reg(prg), .chr1_last(last), .prg_bank_lo(s_plo), .prg_bank_hi(s_phi),
    .chr_bank_lo(s_clo), .chr_bank_hi(s_chi), .mirror(s_mir), .ram_en(s_en),
    .ram_bank(s_bank), .ram_battery(s_batt));

  // ctrl, chr0, chr1, prg, last | plo, phi, clo, chi, mir, en, bank, batt
  typedef struct packed {
    logic [4:0] ctrl, c0, c1, prg;
    logic       last;
    logic [4:0] plo, phi, clo, chi;
    logic [1:0] mir;
    logic       en;
    logic [1:0] bank;
    logic       batt;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{5'h0C, 5'h00, 5'h00, 5'h03, 1'b0, 5'h03, 5'h0F, 5'h00, 5'h01, 2'd0, 1'b1, 2'd0, 1'b1},
    '{5'h08, 5'h10, 5'h00, 5'h05, 1'b0, 5'h10, 5'h15, 5'h10, 5'h11, 2'd0, 1'b1, 2'd0, 1'b1},
    '{5'h01, 5'h0C, 5'h00, 5'h07, 1'b0, 5'h06, 5'h07, 5'h0C, 5'h0D, 2'd1, 1'b1, 2'd3, 1'b1},
    '{5'h1E, 5'h05, 5'h18, 5'h02, 1'b1, 5'h12, 5'h1F, 5'h05, 5'h18, 2'd2, 1'b1, 2'd2, 1'b1},
    '{5'h1E, 5'h05, 5'h18, 5'h02, 1'b0, 5'h02, 5'h0F, 5'h05, 5'h18, 2'd2, 1'b1, 2'd1, 1'b1},
    '{5'h0F, 5'h04, 5'h1C, 5'h13, 1'b1, 5'h03, 5'h0F, 5'h04, 5'h05, 2'd3, 1'b0, 2'd1, 1'b1},
    '{5'h13, 5'h1F, 5'h0A, 5'h0F, 1'b1, 5'h0E, 5'h0F, 5'h1F, 5'h0A, 2'd3, 1'b1, 2'd2, 1'b1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] k, input logic [4:0] x0, input logic [4:0] x1,
                       input logic [4:0] p, input logic l);
    @(negedge clk);
    ctrl = k; c0 = x0; c1 = x1; prg = p; last = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    ctrl = 5'h1F; c0 = 5'h1F; c1 = 5'h1F; prg = 5'h0F; last = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs held at zero in reset
    chk("R11", "reset prg_lo", a_plo, 0);
    chk("R11", "reset prg_hi", a_phi, 0);
    chk("R11", "reset chr_hi", a_chi, 0);
    chk("R11", "reset mirror", a_mir, 0);
    chk("R11", "reset ram_en", a_en, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7 R8 via table on the 512 KB / 32 KB board
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].ctrl, VEC[i].c0, VEC[i].c1, VEC[i].prg, VEC[i].last);
      chk("R2/R3/R6", $sformatf("v%0d prg_lo", i), a_plo, VEC[i].plo);
      chk("R2/R3/R6", $sformatf("v%0d prg_hi", i), a_phi, VEC[i].phi);
      chk("R4", $sformatf("v%0d chr_lo", i), a_clo, VEC[i].clo);
      chk("R4", $sformatf("v%0d chr_hi", i), a_chi, VEC[i].chi);
      chk("R1", $sformatf("v%0d mirror", i), a_mir, VEC[i].mir);
      chk("R7", $sformatf("v%0d ram_en", i), a_en, VEC[i].en);
      chk("R5/R8", $sformatf("v%0d ram_bank", i), a_bank, VEC[i].bank);
      chk("R8", $sformatf("v%0d ram_batt", i), a_batt, VEC[i].batt);
    end

    // R11: change visible only after the next rising edge
    @(negedge clk);
    ctrl = 5'h0E; c0 = 5'h00; c1 = 5'h00; prg = 5'h09; last = 1'b0;
    #1;
    chk("R11", "old prg_lo before edge", a_plo, 5'h0E);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "new prg_lo after edge", a_plo, 5'h09);
    chk("R1", "mirror vertical", a_mir, 2);

    // R10 R9 R7: fixed board, split RAM, forced RAM
    apply(5'h0C, 5'h18, 5'h00, 5'h15, 1'b0);
    chk("R10", "fixed prg_lo", b_plo, 0);
    chk("R10", "fixed prg_hi", b_phi, 1);
    chk("R7", "forced ram_en", b_en, 1);
    chk("R9", "split work select", b_batt, 0);
    chk("R9", "split bank", b_bank, 0);
    chk("R4", "fixed board chr_hi", b_chi, 5'h19);
    apply(5'h1C, 5'h00, 5'h08, 5'h0B, 1'b1);
    chk("R10", "fixed prg_lo other regs", b_plo, 0);
    chk("R5", "split uses chr1 as active", b_batt, 0);
    apply(5'h1C, 5'h10, 5'h00, 5'h0B, 1'b1);
    chk("R9", "split battery select", b_batt, 1);

    // R6 R9: small board has no high bit and no bank
    apply(5'h08, 5'h1C, 5'h00, 5'h04, 1'b0);
    chk("R6", "256K no high bit lo", s_plo, 0);
    chk("R6", "256K no high bit hi", s_phi, 4);
    chk("R9", "8K ram_bank", s_bank, 0);
    chk("R9", "8K no battery", s_batt, 0);
    apply(5'h08, 5'h1C, 5'h00, 5'h14, 1'b0);
    chk("R7", "small ram disabled", s_en, 0);

    // R11: reset again clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11", "re-reset prg_hi", a_phi, 0);
    chk("R11", "re-reset ram_bank", a_bank, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule